// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a counter split into two separately clocked sections, built entirely on one system clock. Each of two count inputs is sampled on that clock, and a falling edge on it advances its own section. The low section is a single binary stage that drives bit 0 of the output. The high section is a divide-by-five stage that drives bits 3..1. When bit 0 of the output is fed back to the high section's count input outside the block, the four output bits together step through the decimal digits 0 to 9.

Two pairs of override inputs take precedence over counting. When both inputs of the "nine" pair are high, the counter loads the value nine. When both inputs of the "clear" pair are high, it loads zero. Both overrides are synchronous in this model: they take effect at the next clock edge and hold the value for as long as they stay asserted.

Top module: `dual_decade_counter`

## Requirements
- R1: The output bit 0 toggles at the first clock edge at which `cnt_a_i` is sampled low after having been sampled high, with no override active. Each falling edge toggles it once.
- R2: Bits 3..1 of the output step 000, 001, 010, 011, 100 and then return to 000. Each step happens at the first clock edge at which `cnt_b_i` is sampled low after having been sampled high, with no override active.
- R3: Rising edges and steady levels on either count input leave the output unchanged.
- R4: When both `clr_a_i` and `clr_b_i` are high and no nine override is active, the output is 0000 after the next clock edge. Either clear input alone has no effect.
- R5: When both `nine_a_i` and `nine_b_i` are high, the output is 1001 after the next clock edge. Either nine input alone has no effect.
- R6: When the nine override and the clear override are active together, the output is 1001.
- R7: A falling edge on a count input is ignored while an override is active. It is not counted later, once the override is released.
- R8: With bit 0 of the output looped back to `cnt_b_i`, successive falling edges on `cnt_a_i` give the output sequence 0,1,…,9,0. The values 10 to 15 never occur.
- R9: While `rst_n` is low at a clock edge, the output becomes 0000.
- R10: A falling edge on `cnt_b_i` leaves bit 0 unchanged, and a falling edge on `cnt_a_i` leaves bits 3..1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_a_i | input | 1 | Count input of the binary section |
| cnt_b_i | input | 1 | Count input of the divide-by-five section |
| clr_a_i | input | 1 | Clear override, first input of the pair |
| clr_b_i | input | 1 | Clear override, second input of the pair |
| nine_a_i | input | 1 | Load-nine override, first input of the pair |
| nine_b_i | input | 1 | Load-nine override, second input of the pair |
| q_o | output | 4 | Count value; bit 0 from the binary section, bits 3..1 from the divide-by-five section |

## Verification
The assertions assume that both count inputs are already synchronous to the system clock. They also assume that each input level is held for at least one clock, so that a registered sample and the current level are enough to define an edge. The stimulus changes every input only on the falling clock edge. It holds each count level for two or more clocks, and in loop-back mode the block's own registered output drives the high section's count input. The ignore case is checked by making a falling edge during an override, then releasing the override and confirming that the value does not move.

// File: rtl/ddc_pkg.sv
// Shared definitions for the dual-section decade counter.
// Assumes: included first in compile order.
package ddc_pkg;
    // Number of independent count inputs (binary section, divide-by-five section)
    localparam int unsigned NUM_CNT = 2;
    localparam int unsigned IDX_LO  = 0;
    localparam int unsigned IDX_HI  = 1;

    // Resolved override action, nine taking priority over clear
    typedef enum logic [1:0] {
        OVR_NONE  = 2'd0,
        OVR_CLEAR = 2'd1,
        OVR_NINE  = 2'd2
    } ovr_e;
endpackage

// File: rtl/ddc_fall_detect.sv
// Falling-edge detector for one count input.
// Keeps the previous sample and flags prev=1, now=0.
// Assumes: the input is synchronous to clk and held at least one cycle per level.
module ddc_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);
    logic prev_q;

    // Register the last sampled level of the count input
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    always_comb fall_o = prev_q & ~lvl_i;

    // R3
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ddc_bin_stage.sv
// Binary section: one bit that toggles on each qualified falling edge.
// Assumes: ovr_i is already priority-resolved.
module ddc_bin_stage
    import ddc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  ovr_e ovr_i,
    output logic q_o
);
    // Toggle, load or hold the binary bit
    always_ff @(posedge clk) begin
        if (!rst_n)                q_o <= 1'b0;
        else if (ovr_i == OVR_NINE)  q_o <= 1'b1;
        else if (ovr_i == OVR_CLEAR) q_o <= 1'b0;
        else if (adv_i)              q_o <= ~q_o;
    end

    // R1
    bin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && ovr_i == OVR_NONE) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/ddc_quinary_stage.sv
// Divide-by-MOD section: counts 0..MOD-1 and wraps to 0.
// The nine override loads MOD-1 (100 for MOD=5), the clear override loads 0.
// Assumes: ovr_i is already priority-resolved; MOD >= 2.
module ddc_quinary_stage
    import ddc_pkg::*;
#(
    parameter int unsigned MOD = 5,
    localparam int unsigned W  = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  ovr_e         ovr_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    // Advance, wrap, load or hold the section state
    always_ff @(posedge clk) begin
        if (!rst_n)                  q_o <= '0;
        else if (ovr_i == OVR_NINE)  q_o <= TOP;
        else if (ovr_i == OVR_CLEAR) q_o <= '0;
        else if (adv_i)              q_o <= (q_o == TOP) ? '0 : q_o + 1'b1;
    end

    // R2
    hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_o <= TOP);
    // R2
    hi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && ovr_i == OVR_NONE && q_o == TOP) |=> (q_o == '0));
endmodule

// File: rtl/ddc_override_ctrl.sv
// Resolves the two override pairs into one action; each pair needs both inputs high.
// Nine has priority over clear.
module ddc_override_ctrl
    import ddc_pkg::*;
(
    input  logic clr_a_i,
    input  logic clr_b_i,
    input  logic nine_a_i,
    input  logic nine_b_i,
    output ovr_e ovr_o
);
    // Priority decode of the override pairs
    always_comb begin
        if (nine_a_i && nine_b_i)     ovr_o = OVR_NINE;
        else if (clr_a_i && clr_b_i)  ovr_o = OVR_CLEAR;
        else                          ovr_o = OVR_NONE;
    end
endmodule

// File: rtl/dual_decade_counter.sv
// Dual-section decade counter top.
// Bit 0 comes from the binary section (count input A). Bits 3..1 come from
// the divide-by-HI_MOD section (count input B). Looping bit 0 to input B outside
// the block gives a decade counter. Assumes synchronous count inputs.
module dual_decade_counter
    import ddc_pkg::*;
#(
    parameter int unsigned HI_MOD = 5,
    localparam int unsigned HI_W  = $clog2(HI_MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_a_i,
    input  logic          cnt_b_i,
    input  logic          clr_a_i,
    input  logic          clr_b_i,
    input  logic          nine_a_i,
    input  logic          nine_b_i,
    output logic [HI_W:0] q_o
);
    logic [NUM_CNT-1:0] lvl;
    logic [NUM_CNT-1:0] fall;
    ovr_e               ovr;
    logic               lo_q;
    logic [HI_W-1:0]    hi_q;

    always_comb lvl = {cnt_b_i, cnt_a_i};

    // One edge detector per count input
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_edge
        ddc_fall_detect u_fall (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[g]),
            .fall_o (fall[g])
        );
    end

    ddc_override_ctrl u_ovr (
        .clr_a_i  (clr_a_i),
        .clr_b_i  (clr_b_i),
        .nine_a_i (nine_a_i),
        .nine_b_i (nine_b_i),
        .ovr_o    (ovr)
    );

    ddc_bin_stage u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (fall[IDX_LO]),
        .ovr_i (ovr),
        .q_o   (lo_q)
    );

    ddc_quinary_stage #(.MOD(HI_MOD)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (fall[IDX_HI]),
        .ovr_i (ovr),
        .q_o   (hi_q)
    );

    always_comb q_o = {hi_q, lo_q};

    // R5
    nine_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_a_i && nine_b_i) |=> (q_o == {HI_W'(HI_MOD - 1), 1'b1}));
    // R4
    clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (q_o == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall[IDX_LO] && !fall[IDX_HI] && !(nine_a_i && nine_b_i)
         && !(clr_a_i && clr_b_i)) |=> $stable(q_o));
    // R10
    lo_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall[IDX_LO] && !(nine_a_i && nine_b_i) && !(clr_a_i && clr_b_i))
        |=> (q_o[0] == $past(q_o[0])));
endmodule

// File: tb/dual_decade_counter_tb_top.sv
// Bench: loop-back decade sweep, section sweeps and override cases.
module dual_decade_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_drv = 1'b0, b_drv = 1'b0, loop_en = 1'b0;
    logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
    logic [3:0] q;
    logic       cnt_b;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign cnt_b = loop_en ? q[0] : b_drv;

    dual_decade_counter dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_a_i(a_drv), .cnt_b_i(cnt_b),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
        .q_o(q)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        n_chk++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", tag, q, exp);
        end
    endtask

    task automatic pulse_a();
        a_drv = 1'b1; tick(2); a_drv = 1'b0; tick(3);
    endtask

    task automatic pulse_b();
        b_drv = 1'b1; tick(2); b_drv = 1'b0; tick(3);
    endtask

    initial begin
        tick(2);
        check("R9 reset", 4'd0);
        rst_n = 1'b1;
        loop_en = 1'b1;
        // R8 R1 R2: two full decades through the loop-back
        for (int i = 1; i <= 20; i++) begin
            pulse_a();
            check("R8 decade", 4'(i % 10));
        end
        loop_en = 1'b0;
        // R2 R10: high section alone, bit 0 held
        for (int n = 1; n <= 7; n++) begin
            pulse_b();
            check("R2/R10 high section", 4'((n % 5) << 1));
        end
        pulse_a();
        check("R10 low section", 4'(((7 % 5) << 1) | 1));
        // R3: rising edge and steady high do nothing
        a_drv = 1'b1; b_drv = 1'b1; tick(4);
        check("R3 rising", 4'd5);
        b_drv = 1'b0; tick(3);
        check("R2 edge after R3", 4'd7);
        // R5: single input, then both
        nine_a = 1'b1; tick(2);
        check("R5 single nine", 4'd7);
        nine_b = 1'b1; tick(2);
        check("R5 nine", 4'd9);
        // R7: falling edge during override, then release
        a_drv = 1'b0; tick(3);
        check("R7 during nine", 4'd9);
        nine_a = 1'b0; nine_b = 1'b0; tick(3);
        check("R7 after nine", 4'd9);
        // R4: single input, then both
        clr_b = 1'b1; tick(2);
        check("R4 single clear", 4'd9);
        clr_a = 1'b1; tick(2);
        check("R4 clear", 4'd0);
        pulse_a();
        check("R7 during clear", 4'd0);
        clr_a = 1'b0; clr_b = 1'b0; tick(3);
        check("R7 after clear", 4'd0);
        // R6: both overrides together, then drop nine
        clr_a = 1'b1; clr_b = 1'b1; nine_a = 1'b1; nine_b = 1'b1; tick(2);
        check("R6 priority", 4'd9);
        nine_b = 1'b0; tick(2);
        check("R6 clear after nine", 4'd0);
        clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; tick(2);
        pulse_a();
        check("R1 resume", 4'd1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule